// File: doc/BRIEF.md
# Hot-Swap Insertion and Extraction Status Register

This block is the 8-bit control and status register of a hot-swappable add-in card, together with the small sequencer behind it. It watches the card's ejector-handle switch and the bus reset. It raises an insertion flag when the bus reset is released with the handle closed. Once software has acknowledged that flag, it is armed to raise an extraction flag when the handle is later opened. Either flag pulls an active-low enumeration request low, unless software has masked the request.

Software reaches the register through a simple single-cycle write port and a read bus that is always valid. The two flags are cleared by writing a one. Three control bits can be read and written: an LED drive bit, a device-hiding arm bit and the enumeration mask. A two-bit interface-code field is read-only and fixed. The handle switch is asynchronous to the clock and passes through a synchronizer of configurable length before the sequencer sees it. The bus reset input is taken as synchronous to `clk`.

Top module: `hsw_status_reg`

## Requirements
- R1: After `rst_n` is released, `rd_data` reads 8'h10, `enum_n` is 1 and `led` is 0. While `bus_rst_n` is low, bits 7 (insertion) and 6 (extraction) read 0.
- R2: After `bus_rst_n` goes high, bit 7 sets on the first clock edge at which the synchronized handle is 0 (closed). The handle input passes through SYNC_STAGES flops, so with the default value of 2 a change on `handle_raw` is acted on at the third edge.
- R3: A write with `wr_data[7]`=1 clears bit 7, and a write with `wr_data[6]`=1 clears bit 6. A write with a 0 in either position leaves that flag unchanged.
- R4: `enum_n` is 0 exactly when (bit 7 or bit 6 is 1) and the mask, bit 1, is 0. Otherwise it is 1.
- R5: Bit 6 sets only when all of these hold: the register is in the armed inserted state (bit 7 has been cleared since the last bus reset release), `bus_rst_n` is 1, the synchronized handle is 1 (open), and bit 3 or bit 2 is 0.
- R6: After bit 6 is cleared, it sets again on the next edge if the conditions of R5 still hold. Bits 7 and 6 are never 1 at the same time.
- R7: Bits 5:4 always read 01 and bit 0 always reads 0. Writes do not change them.
- R8: Bits 3 (LED drive), 2 (device-hiding arm) and 1 (enumeration mask) are read/write and reset to 0. Each write loads them from `wr_data`. `led` equals bit 3.
- R9: Bit 7 sets at most once per bus reset release. Once it is cleared, it stays 0 until `bus_rst_n` has been low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| bus_rst_n | input | 1 | Bus reset, active low, synchronous to clk |
| handle_raw | input | 1 | Ejector-handle switch, 0 = closed, 1 = open, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents |
| enum_n | output | 1 | Enumeration request, active low |
| led | output | 1 | LED drive, high = lit |

## Verification
The assertions assume that `bus_rst_n` is synchronous to `clk` and is never asserted together with a write in a way that the properties do not allow for. Each property that involves a write therefore carries `bus_rst_n` in its antecedent. The stimulus changes every input just after the falling clock edge and holds `handle_raw` for many cycles, so the synchronizer delay is fixed. A cycle-exact behavioural model in the bench is compared with the outputs on every cycle. Directed checks cover the open-handle release, the masked request, extraction blocked by the LED and arm bits, and the re-arm after a clear while the handle is still open.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
   localparam int unsigned REG_W    = 8;
   localparam int unsigned BIT_INS  = 7;
   localparam int unsigned BIT_EXT  = 6;
   localparam int unsigned BIT_PI_H = 5;
   localparam int unsigned BIT_PI_L = 4;
   localparam int unsigned BIT_LED  = 3;
   localparam int unsigned BIT_HIDE = 2;
   localparam int unsigned BIT_MASK = 1;
   localparam logic [1:0]  PI_CODE  = 2'b01;

   typedef struct packed {
      logic       ins;
      logic       ext;
      logic [1:0] pi;
      logic       led_on;
      logic       hide_arm;
      logic       enum_mask;
      logic       rsv;
   } hsw_reg_t;
endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hsw_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= RST_VAL;
      else        chain_q[0] <= d_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= RST_VAL;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hsw_ctl.sv
module hsw_ctl #(
   parameter int unsigned REG_W = hsw_pkg::REG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic             led_on,
   output logic             hide_arm,
   output logic             enum_mask
);
   import hsw_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         led_on    <= 1'b0;
         hide_arm  <= 1'b0;
         enum_mask <= 1'b0;
      end else if (wr_en) begin
         led_on    <= wr_data[BIT_LED];
         hide_arm  <= wr_data[BIT_HIDE];
         enum_mask <= wr_data[BIT_MASK];
      end
   end
endmodule

// File: rtl/hsw_seq.sv
module hsw_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_rst_n,
   input  logic handle_open,
   input  logic clr_ins,
   input  logic clr_ext,
   input  logic led_on,
   input  logic hide_arm,
   output logic ins,
   output logic ext
);
   typedef enum logic [1:0] {
      PH_WAIT_CLOSE = 2'd0,
      PH_FRESH      = 2'd1,
      PH_ARMED      = 2'd2
   } phase_t;

   phase_t phase_q;
   logic   ext_q;
   logic   ext_go;

   assign ext_go = (phase_q == PH_ARMED) && !ext_q && handle_open
                   && (!led_on || !hide_arm);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_WAIT_CLOSE;
         ext_q   <= 1'b0;
      end else if (!bus_rst_n) begin
         phase_q <= PH_WAIT_CLOSE;
         ext_q   <= 1'b0;
      end else begin
         case (phase_q)
            PH_WAIT_CLOSE: if (!handle_open) phase_q <= PH_FRESH;
            PH_FRESH:      if (clr_ins)      phase_q <= PH_ARMED;
            default:       phase_q <= PH_ARMED;
         endcase
         if (ext_go)              ext_q <= 1'b1;
         else if (ext_q && clr_ext) ext_q <= 1'b0;
      end
   end

   assign ins = (phase_q == PH_FRESH);
   assign ext = ext_q;
endmodule

// File: rtl/hsw_status_reg.sv
module hsw_status_reg #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HANDLE_RST  = 1'b1,
   parameter int unsigned REG_W       = hsw_pkg::REG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rst_n,
   input  logic             handle_raw,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             enum_n,
   output logic             led
);
   import hsw_pkg::*;

   if (REG_W != $bits(hsw_reg_t)) begin : g_bad_width
      $error("hsw_status_reg: REG_W must match the register layout");
   end

   logic     handle_s;
   logic     ins, ext;
   logic     led_on, hide_arm, enum_mask;
   logic     clr_ins, clr_ext;
   hsw_reg_t view;

   hsw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(HANDLE_RST)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (handle_raw),
      .q_sync  (handle_s)
   );

   hsw_ctl #(.REG_W(REG_W)) i_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .led_on    (led_on),
      .hide_arm  (hide_arm),
      .enum_mask (enum_mask)
   );

   assign clr_ins = wr_en && wr_data[BIT_INS];
   assign clr_ext = wr_en && wr_data[BIT_EXT];

   hsw_seq i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_rst_n   (bus_rst_n),
      .handle_open (handle_s),
      .clr_ins     (clr_ins),
      .clr_ext     (clr_ext),
      .led_on      (led_on),
      .hide_arm    (hide_arm),
      .ins         (ins),
      .ext         (ext)
   );

   always_comb begin
      view           = '0;
      view.ins       = ins;
      view.ext       = ext;
      view.pi        = PI_CODE;
      view.led_on    = led_on;
      view.hide_arm  = hide_arm;
      view.enum_mask = enum_mask;
      view.rsv       = 1'b0;
   end

   assign rd_data = view;
   assign enum_n  = !((ins || ext) && !enum_mask);
   assign led     = led_on;
endmodule

// File: rtl/hsw_status_chk.sv
module hsw_status_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_rst_n,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic [7:0] rd_data,
   input logic       enum_n,
   input logic       led
);
   a_r1_busrst_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rst_n |=> (!rd_data[7] && !rd_data[6]));

   a_r3_ins_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[7] && rd_data[7] && bus_rst_n) |=> !rd_data[7]);

   a_r3_ins_w0_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[7] && rd_data[7] && bus_rst_n) |=> rd_data[7]);

   a_r3_ext_w0_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[6] && rd_data[6] && bus_rst_n) |=> rd_data[6]);

   a_r4_enum_map: assert property (@(posedge clk) disable iff (!rst_n)
      enum_n == !((rd_data[7] || rd_data[6]) && !rd_data[1]));

   a_r5_ext_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[6]) |-> ($past(bus_rst_n) && !$past(rd_data[7])
                             && !($past(rd_data[3]) && $past(rd_data[2]))));

   a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_data[7] && rd_data[6]));

   a_r7_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[5:4] == 2'b01) && !rd_data[0]);

   a_r8_led_bit: assert property (@(posedge clk) disable iff (!rst_n)
      led == rd_data[3]);

   a_r9_no_reinsert: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_data[7] && bus_rst_n && $past(bus_rst_n) && $past(rd_data[6])) |=> !rd_data[7]);
endmodule

bind hsw_status_reg hsw_status_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_rst_n (bus_rst_n),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .rd_data   (rd_data),
   .enum_n    (enum_n),
   .led       (led)
);

// File: tb/test_hsw_status_reg.sv
module test_hsw_status_reg;
   localparam time CYC = 4ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_rst_n = 1'b0;
   logic       handle_raw = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       enum_n, led;

   int n_run = 0;
   int n_fail = 0;
   bit cmp_on = 1'b0;

   always #(CYC/2) clk = ~clk;

   hsw_status_reg i_hsw_status_reg (
      .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .handle_raw(handle_raw),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .enum_n(enum_n), .led(led)
   );

   // behavioural reference
   bit m_ins, m_ext, m_loo, m_dha, m_msk, m_wait, m_arm;
   bit sq[$];

   task automatic m_reset();
      m_ins = 0; m_ext = 0; m_loo = 0; m_dha = 0; m_msk = 0; m_wait = 1; m_arm = 0;
      sq = '{1'b1, 1'b1};
   endtask

   initial m_reset();

   always @(posedge clk) begin
      if (!rst_n) m_reset();
      else begin
         bit h, n_ins, n_ext, n_arm, n_wait;
         h = sq[1];
         sq.push_front(handle_raw);
         void'(sq.pop_back());
         n_ins = m_ins; n_ext = m_ext; n_arm = m_arm; n_wait = m_wait;
         if (!bus_rst_n) begin
            n_ins = 0; n_ext = 0; n_arm = 0; n_wait = 1;
         end else begin
            if (m_wait && !h) begin n_ins = 1; n_wait = 0; end
            else if (m_ins && wr_en && wr_data[7]) begin n_ins = 0; n_arm = 1; end
            if (m_arm && !m_ext && h && !(m_loo && m_dha)) n_ext = 1;
            else if (m_ext && wr_en && wr_data[6]) n_ext = 0;
         end
         if (wr_en) begin m_loo = wr_data[3]; m_dha = wr_data[2]; m_msk = wr_data[1]; end
         m_ins = n_ins; m_ext = n_ext; m_arm = n_arm; m_wait = n_wait;
      end
   end

   task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (cmp_on) begin
      check(rd_data[7] == m_ins, "R2 ins model", 8'(rd_data[7]), 8'(m_ins));
      check(rd_data[6] == m_ext, "R5 ext model", 8'(rd_data[6]), 8'(m_ext));
      check(rd_data[5:0] == {2'b01, m_loo, m_dha, m_msk, 1'b0}, "R7 low bits model",
            8'(rd_data[5:0]), 8'({2'b01, m_loo, m_dha, m_msk, 1'b0}));
      check(enum_n == !((m_ins || m_ext) && !m_msk), "R4 enum model",
            8'(enum_n), 8'(!((m_ins || m_ext) && !m_msk)));
      check(led == m_loo, "R8 led model", 8'(led), 8'(m_loo));
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wr(logic [7:0] d);
      @(negedge clk); #1; wr_en = 1'b1; wr_data = d;
      @(negedge clk); #1; wr_en = 1'b0; wr_data = '0;
   endtask

   initial begin
      #(CYC * 100000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      cmp_on = 1'b1;
      check(rd_data == 8'h10, "R1 reset value", rd_data, 8'h10);
      check(enum_n && !led, "R1 reset outputs", {6'd0, enum_n, led}, 8'h02);
      // R9 path: release bus reset with handle open, no insertion yet
      cyc(2);
      bus_rst_n = 1'b1;
      cyc(6);
      check(!rd_data[7], "R2 open handle blocks insertion", rd_data, 8'h10);
      handle_raw = 1'b0;
      cyc(2);
      check(!rd_data[7], "R2 sync delay", rd_data, 8'h10);
      cyc(1);
      check(rd_data == 8'h90 && !enum_n, "R2 insertion set", rd_data, 8'h90);
      wr(8'h00);
      check(rd_data[7], "R3 write 0 keeps ins", rd_data, 8'h90);
      wr(8'h02);
      check(enum_n && rd_data == 8'h92, "R4 mask hides request", rd_data, 8'h92);
      wr(8'h82);
      check(rd_data == 8'h12, "R3 write 1 clears ins", rd_data, 8'h12);
      wr(8'h00);
      cyc(5);
      check(!rd_data[7], "R9 no reinsert while closed", rd_data, 8'h10);
      handle_raw = 1'b1;
      cyc(3);
      check(rd_data == 8'h50 && !enum_n, "R5 extraction set", rd_data, 8'h50);
      wr(8'h30);
      check(rd_data == 8'h50, "R7 fixed bits ignore write", rd_data, 8'h50);
      // clear while open: drops for one cycle, then returns
      @(negedge clk); #1; wr_en = 1'b1; wr_data = 8'h40;
      @(negedge clk);
      check(!rd_data[6], "R3 write 1 clears ext", rd_data, 8'h10);
      #1; wr_en = 1'b0; wr_data = '0;
      cyc(1);
      check(rd_data[6], "R6 ext re-arms", rd_data, 8'h50);
      handle_raw = 1'b0;
      cyc(3);
      wr(8'h40);
      wr(8'h0C);
      check(led && rd_data == 8'h1C, "R8 led and arm bits", rd_data, 8'h1C);
      handle_raw = 1'b1;
      cyc(6);
      check(!rd_data[6], "R5 blocked by led and arm", rd_data, 8'h1C);
      wr(8'h08);
      cyc(1);
      check(rd_data[6] && !rd_data[7], "R6 ext after arm drop, exclusive", rd_data, 8'h58);
      // second bus reset with handle closed: fresh insertion
      bus_rst_n = 1'b0;
      cyc(2);
      check(!rd_data[7] && !rd_data[6], "R1 bus reset clears flags", rd_data, 8'h18);
      handle_raw = 1'b0;
      cyc(3);
      bus_rst_n = 1'b1;
      cyc(1);
      check(rd_data[7], "R9 new insertion after bus reset", rd_data, 8'h98);
      wr(8'h80);
      cyc(4);
      cmp_on = 1'b0;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule